// File: doc/BRIEF.md
# SPI master channel controller

This block is one SPI master channel. Software controls it through a small word-addressed register port. It drives the serial clock, a chip select line and two data lines, and it accepts serial input on either data line. Each word is loaded from a transmit holding register and shifted MSB first. The word length runs from 4 to 32 bits, in any of the four clock modes. The bit rate comes from a power-of-two divider of the core clock.

Software picks one of three transfer kinds. In full duplex, every written word is sent and the captured reply is stored. In transmit only, the reply is thrown away. In receive only, the channel clocks out zeros and starts one word after another for as long as it stays enabled. The chip select is never framed per word. Software holds it active and releases it by hand, so a frame can span many words. A module-wide soft reset returns every register to its default value and reports when it has finished.

Register map (word addresses): 0 system config, 1 system status, 2 configuration, 3 status, 4 channel control, 5 transmit data, 6 receive data. Any other address reads as zero.

Top module: `spi_chan_master`

## Requirements
- R1: After reset, the configuration register reads 0 and the status register reads 2 (transmit-empty set, receive-full and end-of-transfer clear). System status bit 0 reads 1, and the serial clock and chip select are both low.
- R2: Configuration bit 1 sets the serial clock idle level. Configuration bit 0 selects the sampling edge. With bit 0 clear, a data bit is presented before the leading clock edge and sampled on it. With bit 0 set, a data bit is presented on the leading edge and sampled on the trailing edge.
- R3: Each serial clock half period lasts 2^N core cycles, where N is configuration bits 5:2. Values of N above 12 act as 12.
- R4: Configuration bits 11:7 hold the word length minus one, for lengths 4 to 32. Field values below 3 act as length 4. A word gives exactly that many leading clock edges, and its data is sent MSB first.
- R5: A received word is right-aligned in the receive register, and all bits above the word length read as zero.
- R6: In full duplex (configuration bits 13:12 = 00), writing the transmit register clears transmit-empty (status bit 1). That bit sets again when the word enters the shifter. Each finished word is stored in the receive register and sets receive-full (status bit 0). Reading the receive register clears receive-full.
- R7: In transmit only (configuration bit 13 set), received bits are discarded and receive-full stays clear.
- R8: In receive only (bit 12 set, bit 13 clear), the channel shifts out zeros and starts a new word after each one completes while it is enabled. Writes to the transmit register have no effect, so transmit-empty stays set.
- R9: End-of-transfer (status bit 2) sets when a word completes and no further word follows. It clears when a word starts. Status bits 1 and 2 both set means the transfer is finished.
- R10: Control bit 0 enables the channel. Clearing it stops shifting at once, returns the serial clock to its idle level and prevents any further received word.
- R11: Configuration bit 6 set makes chip select active low. Bit 20 set drives chip select to its active level. With bit 20 clear, chip select sits at its inactive level.
- R12: Configuration bit 18 selects the input line: 0 samples data line 0 and 1 samples data line 1. Bit 16 disables the driver of data line 0 and bit 17 the driver of data line 1. Both lines carry the outgoing data.
- R13: Writing system config with bit 1 set aborts any transfer and returns all registers to their defaults. While this runs, system status bit 0 reads 0 and register writes are ignored. The bit then returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (needed for the receive-full clear) |
| regAddr | input | 3 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| spiClk | output | 1 | Serial clock |
| spiCs | output | 1 | Chip select |
| line0Out | output | 1 | Data line 0 output value |
| line0Oe | output | 1 | Data line 0 driver enable |
| line1Out | output | 1 | Data line 1 output value |
| line1Oe | output | 1 | Data line 1 driver enable |
| line0In | input | 1 | Data line 0 input |
| line1In | input | 1 | Data line 1 input |

## Verification
The assertions assume software does not rewrite the configuration register while a word is shifting. Under that assumption the word-length and divider values seen by the shift engine stay fixed for the whole word. The bench honours this by clearing the channel enable before every configuration change and re-enabling afterwards. It also waits for receive-full or for transmit-empty together with end-of-transfer before touching the registers again. Serial input comes either from a loopback of the outgoing line or from a constant level, so every expected word follows directly from the transmitted value or the chosen level.

// File: rtl/spi_chan_pkg.sv
package spi_chan_pkg;
  localparam int REG_W       = 32;
  localparam int REG_AW      = 3;
  localparam int MAX_WL      = 32;
  localparam int WL_W        = $clog2(MAX_WL);
  localparam int DIV_LOG_MAX = 12;
  localparam int DIVF_W      = $clog2(DIV_LOG_MAX + 1);

  // configuration field positions (software visible)
  localparam int CF_PHASE  = 0;
  localparam int CF_POL    = 1;
  localparam int CF_DIV    = 2;
  localparam int CF_CSLOW  = 6;
  localparam int CF_WL     = 7;
  localparam int CF_RXONLY = 12;
  localparam int CF_TXONLY = 13;
  localparam int CF_OFF0   = 16;
  localparam int CF_OFF1   = 17;
  localparam int CF_INSEL  = 18;
  localparam int CF_FORCE  = 20;
  localparam logic [REG_W-1:0] CONF_MASK = 32'h0017_3FFF;

  typedef enum logic [REG_AW-1:0] {
    ADDR_SYSCFG  = 3'd0,
    ADDR_SYSSTAT = 3'd1,
    ADDR_CONF    = 3'd2,
    ADDR_STAT    = 3'd3,
    ADDR_CTRL    = 3'd4,
    ADDR_TX      = 3'd5,
    ADDR_RX      = 3'd6
  } regAddr_e;

  typedef struct packed {
    logic start;
    logic stop;
  } engCmd_t;

  typedef struct packed {
    logic busy;
    logic wordDone;
  } engStat_t;
endpackage

// File: rtl/spi_chan_shift.sv
module spi_chan_shift
  import spi_chan_pkg::*;
#(
  parameter int WORD_MAX = MAX_WL,
  parameter int DIV_MAX  = DIV_LOG_MAX
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  engCmd_t                     cmd,
  input  logic [WORD_MAX-1:0]         txWord,
  input  logic [$clog2(WORD_MAX)-1:0] wlm1,
  input  logic [DIVF_W-1:0]           divSel,
  input  logic                        cpol,
  input  logic                        cpha,
  input  logic                        sdi,
  output logic                        sclk,
  output logic                        sdo,
  output engStat_t                    st,
  output logic [WORD_MAX-1:0]         rxWord
);
  localparam int LW     = $clog2(WORD_MAX);
  localparam int HALF_W = LW + 1;
  localparam int CNT_W  = DIV_MAX;

  logic              busy, wordDone, sclkInt, outBit;
  logic [CNT_W-1:0]  divCnt, divLim;
  logic [HALF_W-1:0] halfCnt, lastHalf;
  logic [WORD_MAX-1:0] txSh, rxSh;
  logic tick, leadEdge, trailEdge, sampleNow, shiftNow;

  assign divLim    = CNT_W'((32'd1 << divSel) - 32'd1);
  assign lastHalf  = {wlm1, 1'b1};
  assign tick      = busy && (divCnt == divLim);
  assign leadEdge  = tick && !sclkInt;
  assign trailEdge = tick && sclkInt;
  assign sampleNow = cpha ? trailEdge : leadEdge;
  assign shiftNow  = cpha ? leadEdge : trailEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0; wordDone <= 1'b0; sclkInt <= 1'b0; outBit <= 1'b0;
      divCnt <= '0; halfCnt <= '0; txSh <= '0; rxSh <= '0;
    end else begin
      wordDone <= 1'b0;
      if (cmd.stop) begin
        busy    <= 1'b0;
        sclkInt <= 1'b0;
      end else if (cmd.start && !busy) begin
        busy    <= 1'b1;
        sclkInt <= 1'b0;
        divCnt  <= '0;
        halfCnt <= '0;
        rxSh    <= '0;
        if (!cpha) begin
          outBit <= txWord[wlm1];
          txSh   <= txWord << 1;
        end else begin
          txSh   <= txWord;
        end
      end else if (busy) begin
        divCnt <= tick ? '0 : divCnt + CNT_W'(1);
        if (tick) begin
          sclkInt <= ~sclkInt;
          halfCnt <= halfCnt + HALF_W'(1);
          if (sampleNow) rxSh <= {rxSh[WORD_MAX-2:0], sdi};
          if (shiftNow) begin
            outBit <= txSh[wlm1];
            txSh   <= txSh << 1;
          end
          if (halfCnt == lastHalf) begin
            busy     <= 1'b0;
            wordDone <= 1'b1;
          end
        end
      end
    end
  end

  assign sclk   = sclkInt ^ cpol;
  assign sdo    = outBit;
  assign rxWord = rxSh;
  assign st     = '{busy: busy, wordDone: wordDone};

  // R4
  halfcnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> halfCnt <= lastHalf);
  // R9
  word_done_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordDone |-> $past(busy));
  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmd.stop) |-> (!busy && !sclkInt));
endmodule

// File: rtl/spi_chan_regs.sv
module spi_chan_regs
  import spi_chan_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  engStat_t          st,
  input  logic [MAX_WL-1:0] rxWord,
  output engCmd_t           cmd,
  output logic [MAX_WL-1:0] txWord,
  output logic [WL_W-1:0]   wlm1,
  output logic [DIVF_W-1:0] divSel,
  output logic              cpol,
  output logic              cpha,
  output logic              inSel,
  output logic              csLevel,
  output logic              oe0,
  output logic              oe1
);
  localparam int RC_W = $clog2(RST_CYCLES + 1);

  logic [REG_W-1:0]  conf;
  logic [MAX_WL-1:0] txBuf, rxBuf;
  logic [RC_W-1:0]   rstCnt;
  logic enable, txFull, rxFull, eot;
  logic softRst, softReq, regAcc, txWr, rxRd, modeTxOnly, modeRxOnly, startTx;
  logic [WL_W-1:0]   wlRaw;
  logic [DIVF_W-1:0] divRaw;

  assign softRst    = (rstCnt != '0);
  assign softReq    = wrEn && (addr == ADDR_SYSCFG) && wrData[1];
  assign regAcc     = wrEn && !softRst;
  assign modeTxOnly = conf[CF_TXONLY];
  assign modeRxOnly = conf[CF_RXONLY] && !conf[CF_TXONLY];
  assign txWr       = regAcc && (addr == ADDR_TX) && !modeRxOnly;
  assign rxRd       = rdEn && (addr == ADDR_RX) && !softRst;

  assign cmd.stop  = softRst || !enable;
  assign cmd.start = enable && !softRst && !st.busy && (modeRxOnly || txFull);
  assign startTx   = cmd.start && !modeRxOnly;
  assign txWord    = modeRxOnly ? '0 : txBuf;

  assign wlRaw   = conf[CF_WL +: WL_W];
  assign divRaw  = conf[CF_DIV +: DIVF_W];
  assign wlm1    = (wlRaw < WL_W'(3)) ? WL_W'(3) : wlRaw;
  assign divSel  = (divRaw > DIVF_W'(DIV_LOG_MAX)) ? DIVF_W'(DIV_LOG_MAX) : divRaw;
  assign cpol    = conf[CF_POL];
  assign cpha    = conf[CF_PHASE];
  assign inSel   = conf[CF_INSEL];
  assign csLevel = conf[CF_FORCE] ? ~conf[CF_CSLOW] : conf[CF_CSLOW];
  assign oe0     = ~conf[CF_OFF0];
  assign oe1     = ~conf[CF_OFF1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstCnt <= '0;
    end else if (softReq) begin
      rstCnt <= RC_W'(RST_CYCLES);
    end else if (softRst) begin
      rstCnt <= rstCnt - RC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      conf <= '0; enable <= 1'b0; txBuf <= '0; rxBuf <= '0;
      txFull <= 1'b0; rxFull <= 1'b0; eot <= 1'b0;
    end else if (softReq || softRst) begin
      conf <= '0; enable <= 1'b0; txBuf <= '0; rxBuf <= '0;
      txFull <= 1'b0; rxFull <= 1'b0; eot <= 1'b0;
    end else begin
      if (regAcc && addr == ADDR_CONF) conf <= wrData & CONF_MASK;
      if (regAcc && addr == ADDR_CTRL) enable <= wrData[0];
      if (txWr) txBuf <= wrData[MAX_WL-1:0];
      if (txWr) txFull <= 1'b1;
      else if (startTx) txFull <= 1'b0;
      if (st.wordDone && !modeTxOnly) begin
        rxBuf  <= rxWord;
        rxFull <= 1'b1;
      end else if (rxRd) begin
        rxFull <= 1'b0;
      end
      if (cmd.start) eot <= 1'b0;
      else if (st.wordDone) eot <= 1'b1;
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_SYSSTAT: rdData = REG_W'(!softRst);
      ADDR_CONF:    rdData = conf;
      ADDR_STAT:    rdData = REG_W'({eot, ~txFull, rxFull});
      ADDR_CTRL:    rdData = REG_W'(enable);
      ADDR_RX:      rdData = REG_W'(rxBuf);
      default:      rdData = '0;
    endcase
  end

  // R6
  tx_load_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txFull) |-> $past(txWr));
  // R6
  rx_full_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> $past(st.wordDone));
  // R8
  rx_only_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeRxOnly) && modeRxOnly) |-> !$rose(txFull));
  // R13
  soft_rst_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(softReq) |-> softRst);
endmodule

// File: rtl/spi_chan_master.sv
module spi_chan_master
  import spi_chan_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              spiClk,
  output logic              spiCs,
  output logic              line0Out,
  output logic              line0Oe,
  output logic              line1Out,
  output logic              line1Oe,
  input  logic              line0In,
  input  logic              line1In
);
  engCmd_t           cmd;
  engStat_t          st;
  logic [MAX_WL-1:0] txWord, rxWord;
  logic [WL_W-1:0]   wlm1;
  logic [DIVF_W-1:0] divSel;
  logic cpol, cpha, inSel, sdo;

  spi_chan_regs #(.RST_CYCLES(RST_CYCLES)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .rdEn(regRdEn), .addr(regAddr),
    .wrData(regWrData), .rdData(regRdData), .st(st), .rxWord(rxWord),
    .cmd(cmd), .txWord(txWord), .wlm1(wlm1), .divSel(divSel), .cpol(cpol),
    .cpha(cpha), .inSel(inSel), .csLevel(spiCs), .oe0(line0Oe), .oe1(line1Oe)
  );

  spi_chan_shift #(.WORD_MAX(MAX_WL), .DIV_MAX(DIV_LOG_MAX)) u_shift (
    .clk(clk), .rstN(rstN), .cmd(cmd), .txWord(txWord), .wlm1(wlm1),
    .divSel(divSel), .cpol(cpol), .cpha(cpha),
    .sdi(inSel ? line1In : line0In), .sclk(spiClk), .sdo(sdo),
    .st(st), .rxWord(rxWord)
  );

  assign line0Out = sdo;
  assign line1Out = sdo;
endmodule

// File: tb/test_spi_chan_master.sv
module test_spi_chan_master;
  localparam logic [2:0] A_SYSCFG = 3'd0, A_SYSSTAT = 3'd1, A_CONF = 3'd2,
                         A_STAT = 3'd3, A_CTRL = 3'd4, A_TX = 3'd5, A_RX = 3'd6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, wrEn, rdEn;
  logic [2:0]  addr;
  logic [31:0] wrData, rdData;
  logic spiClk, spiCs, l0o, l0oe, l1o, l1oe;
  logic l0Val, l1Val, loopSel;
  logic line1In;
  assign line1In = loopSel ? l0o : l1Val;

  spi_chan_master i_spi_chan_master (
    .clk(clk), .rstN(rstN), .regWrEn(wrEn), .regRdEn(rdEn), .regAddr(addr),
    .regWrData(wrData), .regRdData(rdData), .spiClk(spiClk), .spiCs(spiCs),
    .line0Out(l0o), .line0Oe(l0oe), .line1Out(l1o), .line1Oe(l1oe),
    .line0In(l0Val), .line1In(line1In)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  bit cpolB = 0, cphaB = 0;

  // serial monitor: edge count, half period, MSB-first capture
  logic prevSclk = 1'b0;
  int leadCnt = 0, gapCnt = 0, lastGap = 0;
  logic [31:0] capWord = '0;
  always @(negedge clk) begin
    prevSclk <= spiClk;
    if (spiClk !== prevSclk) begin
      lastGap <= gapCnt;
      gapCnt  <= 1;
      if (spiClk != cpolB) leadCnt <= leadCnt + 1;
      if ((spiClk != cpolB) == !cphaB) capWord <= {capWord[30:0], l0o};
    end else begin
      gapCnt <= gapCnt + 1;
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0; #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1; #1; d = rdData;
    @(negedge clk); rdEn = 1'b0; #1;
  endtask

  task automatic waitStat(input logic [31:0] m, input logic [31:0] v, input int maxRd, input string tag);
    logic [31:0] s;
    for (int n = 0; n < maxRd; n++) begin
      rd(A_STAT, s);
      if ((s & m) == v) return;
    end
    chk({tag, " wait timeout"}, s & m, v);
  endtask

  function automatic logic [31:0] mkConf(input bit ph, input bit po, input int dv, input int wlf,
      input bit rxo, input bit txo, input bit csl, input bit off0, input bit off1,
      input bit insel, input bit frc);
    logic [31:0] c;
    c = '0;
    c[0] = ph; c[1] = po; c[5:2] = 4'(dv); c[6] = csl; c[11:7] = 5'(wlf);
    c[12] = rxo; c[13] = txo; c[16] = off0; c[17] = off1; c[18] = insel; c[20] = frc;
    return c;
  endfunction

  function automatic int wlOf(input int i);
    case (i)
      0: return 4;  1: return 7;  2: return 8;
      3: return 16; 4: return 31; default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] maskOf(input int wl);
    return (wl >= 32) ? 32'hFFFF_FFFF : ((32'd1 << wl) - 32'd1);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [31:0] r, val, msk;
    int lead0, wl, dv, iter;
    rstN = 0; wrEn = 0; rdEn = 0; addr = '0; wrData = '0;
    l0Val = 0; l1Val = 0; loopSel = 0;
    repeat (5) @(negedge clk);
    rstN = 1;
    #1;

    // R1 reset state
    rd(A_CONF, r);    chk("R1 conf reset", r, 32'h0);
    rd(A_STAT, r);    chk("R1 stat reset", r, 32'h2);
    rd(A_SYSSTAT, r); chk("R1 reset-done", r, 32'h1);
    chk("R1 sclk idle", {31'b0, spiClk}, 32'h0);
    chk("R1 cs idle", {31'b0, spiCs}, 32'h0);

    // full-duplex loopback sweep: R2 R3 R4 R5 R6 R9
    loopSel = 1;
    iter = 0;
    for (int m = 0; m < 4; m++) begin
      for (int wi = 0; wi < 6; wi++) begin
        for (int di = 0; di < 2; di++) begin
          wl = wlOf(wi); dv = di * 2; msk = maskOf(wl);
          cphaB = m[0]; cpolB = m[1];
          wr(A_CTRL, 32'h0);
          wr(A_CONF, mkConf(m[0], m[1], dv, wl - 1, 0, 0, 0, 0, 0, 1, 1));
          wr(A_CTRL, 32'h1);
          val = (32'hA5C3_96E1 ^ (32'(iter) * 32'h01F3_D5B7)) & msk;
          iter++;
          lead0 = leadCnt;
          wr(A_TX, val);
          waitStat(32'h1, 32'h1, 200, "R6 rx-full");
          rd(A_RX, r);
          chk($sformatf("R5 R6 loopback mode%0d wl%0d", m, wl), r, val);
          chk($sformatf("R2 R4 msb-first capture mode%0d wl%0d", m, wl), capWord & msk, val);
          chk($sformatf("R4 edge count wl%0d", wl), 32'(leadCnt - lead0), 32'(wl));
          chk($sformatf("R3 half period div%0d", dv), 32'(lastGap), 32'd1 << dv);
          rd(A_STAT, r);
          chk("R9 done status", r, 32'h6);
        end
      end
    end

    // R3 divider clamp and R4 length clamp
    cphaB = 0; cpolB = 0;
    wr(A_CTRL, 32'h0);
    wr(A_CONF, mkConf(0, 0, 15, 1, 0, 0, 0, 0, 0, 1, 0));
    wr(A_CTRL, 32'h1);
    lead0 = leadCnt;
    wr(A_TX, 32'h9);
    waitStat(32'h1, 32'h1, 20000, "R3 clamp");
    rd(A_RX, r);
    chk("R4 clamped length data", r, 32'h9);
    chk("R3 divider clamp to 4096", 32'(lastGap), 32'd4096);
    chk("R4 length clamp edges", 32'(leadCnt - lead0), 32'd4);

    // R7 transmit only, back to back words
    wr(A_CTRL, 32'h0);
    wr(A_CONF, mkConf(0, 0, 1, 7, 0, 1, 0, 0, 0, 1, 0));
    wr(A_CTRL, 32'h1);
    lead0 = leadCnt;
    wr(A_TX, 32'h3C);
    wr(A_TX, 32'hA5);
    rd(A_STAT, r);
    chk("R6 tx-empty clear while pending", r & 32'h2, 32'h0);
    chk("R9 eot clear while busy", r & 32'h4, 32'h0);
    waitStat(32'h6, 32'h6, 400, "R9 tx-only done");
    chk("R7 second word on line", capWord & 32'hFF, 32'hA5);
    chk("R7 two words of edges", 32'(leadCnt - lead0), 32'd16);
    rd(A_STAT, r);
    chk("R7 rx-full stays clear", r & 32'h1, 32'h0);

    // R8 R12 receive only
    loopSel = 0; l0Val = 1; l1Val = 0;
    wr(A_CTRL, 32'h0);
    wr(A_CONF, mkConf(0, 0, 0, 11, 1, 0, 0, 0, 0, 0, 0));
    wr(A_CTRL, 32'h1);
    waitStat(32'h1, 32'h1, 200, "R8 first word");
    rd(A_RX, r);
    chk("R5 R12 line0 input ones", r, 32'hFFF);
    waitStat(32'h1, 32'h1, 200, "R8 relaunch");
    rd(A_RX, r);
    chk("R8 auto relaunch word", r, 32'hFFF);
    chk("R8 zeros shifted out", capWord & 32'hFFF, 32'h0);
    wr(A_TX, 32'h123);
    rd(A_STAT, r);
    chk("R8 tx write ignored", r & 32'h2, 32'h2);
    wr(A_CTRL, 32'h0);
    rd(A_RX, r);
    cpolB = 1;
    wr(A_CONF, mkConf(0, 1, 0, 11, 1, 0, 0, 0, 0, 1, 0));
    wr(A_CTRL, 32'h1);
    waitStat(32'h1, 32'h1, 200, "R12 line1");
    rd(A_RX, r);
    chk("R12 line1 input zeros", r, 32'h0);

    // R10 disable stops reception
    wr(A_CTRL, 32'h0);
    rd(A_RX, r);
    lead0 = leadCnt;
    repeat (300) @(negedge clk);
    #1;
    rd(A_STAT, r);
    chk("R10 no word after disable", r & 32'h1, 32'h0);
    chk("R10 clock at idle level", {31'b0, spiClk}, 32'h1);
    chk("R10 no edges after disable", 32'(leadCnt - lead0), 32'h0);

    // R11 chip select
    wr(A_CONF, mkConf(0, 0, 0, 7, 0, 0, 1, 0, 0, 0, 0));
    chk("R11 active-low inactive", {31'b0, spiCs}, 32'h1);
    wr(A_CONF, mkConf(0, 0, 0, 7, 0, 0, 1, 0, 0, 0, 1));
    chk("R11 active-low forced", {31'b0, spiCs}, 32'h0);
    wr(A_CONF, mkConf(0, 0, 0, 7, 0, 0, 0, 0, 0, 0, 1));
    chk("R11 active-high forced", {31'b0, spiCs}, 32'h1);
    wr(A_CONF, mkConf(0, 0, 0, 7, 0, 0, 0, 0, 0, 0, 0));
    chk("R11 active-high inactive", {31'b0, spiCs}, 32'h0);

    // R12 driver enables
    wr(A_CONF, mkConf(0, 0, 0, 7, 0, 0, 0, 1, 0, 0, 0));
    chk("R12 line0 driver off", {30'b0, l0oe, l1oe}, 32'h1);
    wr(A_CONF, mkConf(0, 0, 0, 7, 0, 0, 0, 0, 1, 0, 0));
    chk("R12 line1 driver off", {30'b0, l0oe, l1oe}, 32'h2);

    // R13 soft reset
    wr(A_CONF, 32'h0000_1234);
    wr(A_CTRL, 32'h1);
    wr(A_SYSCFG, 32'h2);
    rd(A_SYSSTAT, r);
    chk("R13 reset in progress", r, 32'h0);
    wr(A_CONF, 32'h0000_00FF);
    repeat (10) @(negedge clk);
    #1;
    rd(A_SYSSTAT, r);
    chk("R13 reset done", r, 32'h1);
    rd(A_CONF, r);
    chk("R13 conf back to default", r, 32'h0);
    rd(A_CTRL, r);
    chk("R13 enable cleared", r, 32'h0);
    rd(A_STAT, r);
    chk("R13 status default", r, 32'h2);

    finishRun();
  end
endmodule